// File: doc/BRIEF.md
# HDLC Transmit Buffer Sequencer

This block turns one transmit buffer descriptor into the ordered byte stream of an HDLC-style channel. When a descriptor that is marked ready is started, the block takes the buffer's bytes from a valid/ready byte source and writes them into a downstream transmit FIFO. Depending on the descriptor's control fields, it then appends a frame check sequence, the closing flag and a programmable run of idle pad characters.

After the final byte of the buffer has gone into the FIFO, the block pulses a completion strobe. With that strobe it presents the write-back values for the descriptor: the new ready bit, an error flag, and the user bit and length, both returned untouched. Continuous mode keeps the descriptor ready so that the same buffer is sent again. An error always clears the ready bit. An optional signal-unit delay holds the buffer back for a number of 512 µs ticks before its first byte.

Top module: `hdlc_txbd_sequencer`

## Requirements
- R1: A start request whose ready bit is 0 is ignored: busy stays 0, nothing is written to the FIFO and no completion strobe occurs.
- R2: The buffer's bytes are written to the FIFO in the order they are received, exactly `bd_len` of them, and no byte is taken from the source or written while `fifo_full` is 1.
- R3: When the last bit is 0, the buffer ends after its final data byte, with no check sequence, flag or pad.
- R4: When last and check-enable are both 1, two check bytes follow the data. They come from CRC-16 with polynomial x^16+x^12+x^5+1, processed LSB-first (reflected constant 0x8408) and preset to 0xFFFF. The value is complemented and sent low byte first, so the bytes "123456789" are followed by 0x6E, 0x90. The flag 0x7E then follows.
- R5: When last is 1 and check-enable is 0, the flag 0x7E follows the final data byte directly.
- R6: After the flag, `bd_pad` idle bytes (0 to 15) are written. Each is 0xFF when `cfg_idle_ones` is 1 and 0x7E when it is 0.
- R7: `txb_done` is a single-cycle pulse. It comes in the cycle after the final byte of the buffer (data, flag or last pad) is written, so every pad byte is in the FIFO before it.
- R8: During `txb_done`, `wb_ready` is 1 only when continuous mode was set and no error occurred; otherwise it is 0.
- R9: A `tx_err` seen during the data phase stops the buffer. No further byte is written, and completion follows with `wb_err` = 1 and `wb_ready` = 0.
- R10: A descriptor with a data length of 0 writes no bytes and completes with `wb_err` = 1 and `wb_ready` = 0.
- R11: When `bd_sud` and `cfg_sud_en` are both 1, no byte is taken or written until `cfg_sud_delay` ticks of `tick_512us` have been counted after the start. When either bit is 0, no wait occurs.
- R12: `wb_user` and `wb_len` return the started descriptor's user bit and length unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bd_start | input | 1 | Start request for the presented descriptor (taken while idle) |
| bd_ready | input | 1 | Descriptor ready bit |
| bd_last | input | 1 | Buffer ends the frame |
| bd_fcs_en | input | 1 | Append check sequence (used only with last) |
| bd_cont | input | 1 | Continuous mode: keep ready after closing |
| bd_user | input | 1 | User bit, passed through |
| bd_sud | input | 1 | Request the signal-unit delay before sending |
| bd_pad | input | PAD_W | Idle pad count after the flag |
| bd_len | input | LEN_W | Data length in bytes |
| cfg_idle_ones | input | 1 | Pad character select: 1 gives 0xFF, 0 gives 0x7E |
| cfg_sud_en | input | 1 | Enable the signal-unit delay feature |
| cfg_sud_delay | input | DLY_W | Delay length in ticks |
| tick_512us | input | 1 | Single-cycle pulse every 512 µs |
| tx_err | input | 1 | Transmission error during the data phase |
| in_valid | input | 1 | Source byte valid |
| in_data | input | 8 | Source byte |
| in_ready | output | 1 | Source byte accepted this cycle when valid |
| fifo_full | input | 1 | Downstream FIFO cannot take a byte |
| fifo_wr | output | 1 | FIFO write strobe |
| fifo_data | output | 8 | Byte written to the FIFO |
| busy | output | 1 | A descriptor is in progress |
| txb_done | output | 1 | Buffer completion pulse |
| wb_ready | output | 1 | Ready bit to write back |
| wb_err | output | 1 | Error flag to write back |
| wb_user | output | 1 | User bit to write back |
| wb_len | output | LEN_W | Length to write back |

## Verification
The hardest case to reach is an error that lands in the middle of the data phase while continuous mode is set. It needs a `tx_err` pulse timed to a specific data byte. The bench raises it right after its monitor has counted a chosen number of FIFO writes, then checks that no later byte appears and that the write-back drops ready. The tick-delay count is observed the same way: the monitor counts the ticks it sees between the start and the first write. The FIFO-full stalls are produced by a shift-register pattern, and gaps in the source bytes by a cycle counter. Together these make the stalls and source gaps fall in the data, check, flag and pad phases.

// File: rtl/hdlc_txbd_pkg.sv
// Shared definitions for the transmit buffer sequencer: sequencer states,
// fixed byte values and the check-sequence constants.
package hdlc_txbd_pkg;
    localparam int BYTE_W = 8;

    localparam logic [BYTE_W-1:0] FLAG_BYTE  = 8'h7E;
    localparam logic [BYTE_W-1:0] ONES_BYTE  = 8'hFF;
    localparam logic [15:0]       FCS_PRESET = 16'hFFFF;
    localparam logic [15:0]       FCS_POLY_R = 16'h8408;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_WAIT,
        ST_DATA,
        ST_FCS_LO,
        ST_FCS_HI,
        ST_FLAG,
        ST_PAD,
        ST_CLOSE
    } seq_state_t;
endpackage

// File: rtl/fcs16_unit.sv
// Running CRC-16 over the payload bytes, LSB-first (reflected polynomial).
// Assumes: clear and advance are never high in the same cycle; advance marks
// one accepted data byte.
module fcs16_unit
    import hdlc_txbd_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clear,
    input  logic              advance,
    input  logic [BYTE_W-1:0] byte_in,
    output logic [15:0]       fcs_tx
);
    logic [15:0] fcs_q;
    logic [15:0] fcs_next;

    // Fold one byte into the register, bit 0 first.
    always_comb begin
        fcs_next = fcs_q ^ {8'h00, byte_in};
        for (int b = 0; b < BYTE_W; b++) begin
            fcs_next = fcs_next[0] ? ((fcs_next >> 1) ^ FCS_POLY_R) : (fcs_next >> 1);
        end
    end

    // Hold the running remainder; preset on clear.
    always_ff @(posedge clk) begin
        if (!rst_n || clear) fcs_q <= FCS_PRESET;
        else if (advance)    fcs_q <= fcs_next;
    end

    assign fcs_tx = ~fcs_q;

    p_fcs_preset_r4: assert property (@(posedge clk) disable iff (!rst_n)
        clear |=> (fcs_tx == ~FCS_PRESET))
        else $error("check sequence not preset after clear");
endmodule

// File: rtl/sud_wait_timer.sv
// Tick counter for the signal-unit delay.
// Assumes: load is given once per descriptor; fire marks the tick that ends
// the wait, and never comes when the loaded count was 0.
module sud_wait_timer #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    input  logic             tick,
    output logic             fire
);
    logic [CNT_W-1:0] left_q;

    // Count remaining ticks down to zero.
    always_ff @(posedge clk) begin
        if (!rst_n)                          left_q <= '0;
        else if (load)                       left_q <= load_val;
        else if (tick && (left_q != '0))     left_q <= left_q - 1'b1;
    end

    assign fire = tick && !load && (left_q == {{(CNT_W-1){1'b0}}, 1'b1});

    p_tick_step_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && !load && (left_q != '0)) |=> (left_q == $past(left_q) - 1'b1))
        else $error("delay counter did not step on tick");
endmodule

// File: rtl/tx_byte_mux.sv
// Chooses the byte offered to the FIFO in each sequencer state.
// Assumes: purely combinational; the caller gates the write with fifo_full.
module tx_byte_mux
    import hdlc_txbd_pkg::*;
(
    input  seq_state_t        state,
    input  logic              in_valid,
    input  logic [BYTE_W-1:0] in_data,
    input  logic              tx_err,
    input  logic [15:0]       fcs_tx,
    input  logic              idle_ones,
    output logic              emit,
    output logic [BYTE_W-1:0] byte_out
);
    // Per-state byte selection and offer.
    always_comb begin
        emit     = 1'b0;
        byte_out = FLAG_BYTE;
        unique case (state)
            ST_DATA: begin
                emit     = in_valid && !tx_err;
                byte_out = in_data;
            end
            ST_FCS_LO: begin
                emit     = 1'b1;
                byte_out = fcs_tx[7:0];
            end
            ST_FCS_HI: begin
                emit     = 1'b1;
                byte_out = fcs_tx[15:8];
            end
            ST_FLAG: begin
                emit     = 1'b1;
                byte_out = FLAG_BYTE;
            end
            ST_PAD: begin
                emit     = 1'b1;
                byte_out = idle_ones ? ONES_BYTE : FLAG_BYTE;
            end
            default: begin
                emit     = 1'b0;
                byte_out = FLAG_BYTE;
            end
        endcase
    end
endmodule

// File: rtl/hdlc_txbd_sequencer.sv
// Sequences one transmit buffer descriptor: optional tick delay, data bytes,
// check sequence, closing flag, idle pad, then a completion pulse with the
// write-back values.
// Assumes: descriptor fields are valid in the cycle bd_start is high;
// a byte moves into the FIFO when fifo_wr is high (fifo_full already low).
module hdlc_txbd_sequencer
    import hdlc_txbd_pkg::*;
#(
    parameter int LEN_W = 16,
    parameter int PAD_W = 4,
    parameter int DLY_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bd_start,
    input  logic              bd_ready,
    input  logic              bd_last,
    input  logic              bd_fcs_en,
    input  logic              bd_cont,
    input  logic              bd_user,
    input  logic              bd_sud,
    input  logic [PAD_W-1:0]  bd_pad,
    input  logic [LEN_W-1:0]  bd_len,
    input  logic              cfg_idle_ones,
    input  logic              cfg_sud_en,
    input  logic [DLY_W-1:0]  cfg_sud_delay,
    input  logic              tick_512us,
    input  logic              tx_err,
    input  logic              in_valid,
    input  logic [7:0]        in_data,
    output logic              in_ready,
    input  logic              fifo_full,
    output logic              fifo_wr,
    output logic [7:0]        fifo_data,
    output logic              busy,
    output logic              txb_done,
    output logic              wb_ready,
    output logic              wb_err,
    output logic              wb_user,
    output logic [LEN_W-1:0]  wb_len
);
    localparam logic [LEN_W-1:0] LEN_ONE = {{(LEN_W-1){1'b0}}, 1'b1};
    localparam logic [PAD_W-1:0] PAD_ONE = {{(PAD_W-1){1'b0}}, 1'b1};

    seq_state_t       state_q, state_d;
    logic             last_q, fcs_en_q, cont_q, user_q, err_q;
    logic [PAD_W-1:0] pad_q, pad_left_q;
    logic [LEN_W-1:0] len_q, remain_q;

    logic        accept, use_wait, in_fire, emit, timer_fire;
    logic [7:0]  mux_byte;
    logic [15:0] fcs_tx;

    assign accept   = (state_q == ST_IDLE) && bd_start && bd_ready;
    assign use_wait = bd_sud && cfg_sud_en && (cfg_sud_delay != '0);
    assign in_ready = (state_q == ST_DATA) && !fifo_full && !tx_err;
    assign in_fire  = in_ready && in_valid;

    fcs16_unit i_fcs (
        .clk     (clk),
        .rst_n   (rst_n),
        .clear   (accept),
        .advance (in_fire),
        .byte_in (in_data),
        .fcs_tx  (fcs_tx)
    );

    sud_wait_timer #(.CNT_W(DLY_W)) i_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (accept),
        .load_val (cfg_sud_delay),
        .tick     (tick_512us),
        .fire     (timer_fire)
    );

    tx_byte_mux i_mux (
        .state     (state_q),
        .in_valid  (in_valid),
        .in_data   (in_data),
        .tx_err    (tx_err),
        .fcs_tx    (fcs_tx),
        .idle_ones (cfg_idle_ones),
        .emit      (emit),
        .byte_out  (mux_byte)
    );

    assign fifo_wr   = emit && !fifo_full;
    assign fifo_data = mux_byte;

    // Next-state selection for the buffer sequence.
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (accept) begin
                    if (bd_len == '0)  state_d = ST_CLOSE;
                    else if (use_wait) state_d = ST_WAIT;
                    else               state_d = ST_DATA;
                end
            end
            ST_WAIT: begin
                if (timer_fire) state_d = ST_DATA;
            end
            ST_DATA: begin
                if (tx_err) state_d = ST_CLOSE;
                else if (in_fire && (remain_q == LEN_ONE)) begin
                    if (!last_q)       state_d = ST_CLOSE;
                    else if (fcs_en_q) state_d = ST_FCS_LO;
                    else               state_d = ST_FLAG;
                end
            end
            ST_FCS_LO: begin
                if (!fifo_full) state_d = ST_FCS_HI;
            end
            ST_FCS_HI: begin
                if (!fifo_full) state_d = ST_FLAG;
            end
            ST_FLAG: begin
                if (!fifo_full) state_d = (pad_q == '0) ? ST_CLOSE : ST_PAD;
            end
            ST_PAD: begin
                if (!fifo_full && (pad_left_q == PAD_ONE)) state_d = ST_CLOSE;
            end
            ST_CLOSE: state_d = ST_IDLE;
            default:  state_d = ST_IDLE;
        endcase
    end

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Capture the descriptor control fields when a start is taken.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            last_q   <= 1'b0;
            fcs_en_q <= 1'b0;
            cont_q   <= 1'b0;
            user_q   <= 1'b0;
            pad_q    <= '0;
            len_q    <= '0;
        end else if (accept) begin
            last_q   <= bd_last;
            fcs_en_q <= bd_fcs_en;
            cont_q   <= bd_cont;
            user_q   <= bd_user;
            pad_q    <= bd_pad;
            len_q    <= bd_len;
        end
    end

    // Remaining data byte count.
    always_ff @(posedge clk) begin
        if (!rst_n)       remain_q <= '0;
        else if (accept)  remain_q <= bd_len;
        else if (in_fire) remain_q <= remain_q - 1'b1;
    end

    // Remaining pad byte count, loaded as the flag is written.
    always_ff @(posedge clk) begin
        if (!rst_n) pad_left_q <= '0;
        else if ((state_q == ST_FLAG) && !fifo_full) pad_left_q <= pad_q;
        else if ((state_q == ST_PAD) && !fifo_full)  pad_left_q <= pad_left_q - 1'b1;
    end

    // Error flag: zero length at start or a data-phase error.
    always_ff @(posedge clk) begin
        if (!rst_n)      err_q <= 1'b0;
        else if (accept) err_q <= (bd_len == '0);
        else if ((state_q == ST_DATA) && tx_err) err_q <= 1'b1;
    end

    assign busy     = (state_q != ST_IDLE);
    assign txb_done = (state_q == ST_CLOSE);
    assign wb_ready = cont_q && !err_q;
    assign wb_err   = err_q;
    assign wb_user  = user_q;
    assign wb_len   = len_q;

    p_no_take_when_full_r2: assert property (@(posedge clk) disable iff (!rst_n)
        fifo_full |-> !(in_ready || fifo_wr))
        else $error("byte moved while FIFO full");

    p_data_left_nonzero_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_DATA) |-> (remain_q != '0))
        else $error("data phase with nothing left");

    p_nonlast_no_trailer_r3: assert property (@(posedge clk) disable iff (!rst_n)
        ((state_q == ST_FLAG) || (state_q == ST_FCS_LO)) |-> last_q)
        else $error("trailer on a non-last buffer");

    p_fcs_hi_after_lo_r4: assert property (@(posedge clk) disable iff (!rst_n)
        ((state_q == ST_FCS_HI) && !$stable(state_q)) |-> ($past(state_q) == ST_FCS_LO))
        else $error("check high byte without low byte");

    p_pad_left_nonzero_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_PAD) |-> (pad_left_q != '0))
        else $error("pad phase with no pad left");

    p_done_after_write_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (txb_done && !wb_err) |-> $past(fifo_wr))
        else $error("completion not right after final write");

    p_done_single_r7: assert property (@(posedge clk) disable iff (!rst_n)
        txb_done |=> !txb_done)
        else $error("completion longer than one cycle");

    p_err_clears_ready_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (txb_done && wb_err) |-> !wb_ready)
        else $error("ready kept after error");

    p_err_stops_data_r9: assert property (@(posedge clk) disable iff (!rst_n)
        ((state_q == ST_DATA) && tx_err) |=> (txb_done && wb_err))
        else $error("error did not end the buffer");

    p_quiet_while_wait_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_WAIT) |-> !(fifo_wr || in_ready))
        else $error("traffic during signal-unit delay");

    p_ignored_start_r1: assert property (@(posedge clk) disable iff (!rst_n)
        ((state_q == ST_IDLE) && bd_start && !bd_ready) |=> !busy)
        else $error("start without ready taken");
endmodule

// File: tb/test_hdlc_txbd_sequencer.sv
module test_hdlc_txbd_sequencer;
    localparam int LEN_W = 16;
    localparam int PAD_W = 4;
    localparam int DLY_W = 8;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic bd_start = 0, bd_ready = 0, bd_last = 0, bd_fcs_en = 0, bd_cont = 0;
    logic bd_user = 0, bd_sud = 0;
    logic [PAD_W-1:0] bd_pad = '0;
    logic [LEN_W-1:0] bd_len = '0;
    logic cfg_idle_ones = 0, cfg_sud_en = 0;
    logic [DLY_W-1:0] cfg_sud_delay = '0;
    logic tick_512us = 0, tx_err = 0, in_valid = 0, fifo_full = 0;
    logic [7:0] in_data = '0;
    logic in_ready, fifo_wr, busy, txb_done, wb_ready, wb_err, wb_user;
    logic [7:0] fifo_data;
    logic [LEN_W-1:0] wb_len;

    always #4 clk = ~clk;

    hdlc_txbd_sequencer #(.LEN_W(LEN_W), .PAD_W(PAD_W), .DLY_W(DLY_W)) i_hdlc_txbd_sequencer (
        .clk(clk), .rst_n(rst_n), .bd_start(bd_start), .bd_ready(bd_ready),
        .bd_last(bd_last), .bd_fcs_en(bd_fcs_en), .bd_cont(bd_cont),
        .bd_user(bd_user), .bd_sud(bd_sud), .bd_pad(bd_pad), .bd_len(bd_len),
        .cfg_idle_ones(cfg_idle_ones), .cfg_sud_en(cfg_sud_en),
        .cfg_sud_delay(cfg_sud_delay), .tick_512us(tick_512us), .tx_err(tx_err),
        .in_valid(in_valid), .in_data(in_data), .in_ready(in_ready),
        .fifo_full(fifo_full), .fifo_wr(fifo_wr), .fifo_data(fifo_data),
        .busy(busy), .txb_done(txb_done), .wb_ready(wb_ready), .wb_err(wb_err),
        .wb_user(wb_user), .wb_len(wb_len)
    );

    int n_checks = 0;
    int n_fails  = 0;
    string cur_tag = "R2";

    logic [7:0] src_q[$];
    logic [7:0] exp_q[$];
    int  wr_seen = 0;
    int  ticks_before = 0;
    bit  first_wr = 0;
    int  err_at = 0;
    bit  stall_en = 0, gap_en = 0, tick_en = 0;
    logic [7:0] lfsr = 8'hA5;
    int  cyc = 0;

    task automatic check(input bit ok, input string tag, input string what,
                         input longint act, input longint exp);
        n_checks++;
        if (!ok) begin
            n_fails++;
            $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
        end
    endtask

    function automatic logic [15:0] ref_fcs(input logic [7:0] bytes[$]);
        logic [15:0] c = 16'hFFFF;
        foreach (bytes[k]) begin
            c ^= {8'h00, bytes[k]};
            for (int b = 0; b < 8; b++) c = c[0] ? ((c >> 1) ^ 16'h8408) : (c >> 1);
        end
        return ~c;
    endfunction

    // Scoreboard monitor and input driver for the byte source, FIFO and tick.
    initial begin
        forever begin
            bit hs;
            @(negedge clk);
            hs = in_valid && in_ready;
            if (rst_n && fifo_wr) begin
                wr_seen++;
                first_wr = 1;
                if (exp_q.size() == 0) begin
                    check(0, cur_tag, "unexpected FIFO write (R2)", fifo_data, 0);
                end else begin
                    logic [7:0] e;
                    e = exp_q.pop_front();
                    check(fifo_data == e, cur_tag, "FIFO byte", fifo_data, e);
                end
            end
            if (tick_512us && busy && !first_wr) ticks_before++;
            @(posedge clk);
            #1;
            cyc++;
            if (hs && src_q.size() > 0) void'(src_q.pop_front());
            lfsr      = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
            in_valid  = (src_q.size() > 0) && !(gap_en && (cyc % 3 == 0));
            in_data   = (src_q.size() > 0) ? src_q[0] : 8'h00;
            fifo_full = stall_en && lfsr[0] && lfsr[1];
            tick_512us = tick_en && (cyc % 5 == 0);
            tx_err    = (err_at > 0) && busy && (wr_seen == err_at);
        end
    end

    // Run one descriptor through the block and check its write-back.
    task automatic run_bd(input string tag, input int len, input bit last,
                          input bit fcs, input bit cont, input bit user,
                          input bit sud, input int pad, input int err_n,
                          input bit known);
        logic [7:0] d[$];
        int sent;
        bit exp_err;
        bit seen;
        @(posedge clk);
        #3;
        for (int i = 0; i < len; i++)
            d.push_back(known ? 8'(8'h31 + i) : 8'((i * 37 + len * 11 + 5) & 8'hFF));
        sent = (err_n > 0) ? err_n : len;
        exp_err = (err_n > 0) || (len == 0);
        for (int i = 0; i < len; i++) src_q.push_back(d[i]);
        for (int i = 0; i < sent; i++) exp_q.push_back(d[i]);
        if (!exp_err && last) begin
            if (fcs) begin
                logic [15:0] f;
                f = known ? 16'h906E : ref_fcs(d);
                exp_q.push_back(f[7:0]);
                exp_q.push_back(f[15:8]);
            end
            exp_q.push_back(8'h7E);
            for (int i = 0; i < pad; i++) exp_q.push_back(cfg_idle_ones ? 8'hFF : 8'h7E);
        end
        wr_seen = 0; first_wr = 0; ticks_before = 0; err_at = err_n; cur_tag = tag;
        bd_ready = 1; bd_last = last; bd_fcs_en = fcs; bd_cont = cont;
        bd_user = user; bd_sud = sud; bd_pad = PAD_W'(pad); bd_len = LEN_W'(len);
        bd_start = 1;
        @(posedge clk);
        #3;
        bd_start = 0;
        seen = 0;
        for (int t = 0; t < 3000 && !seen; t++) begin
            @(negedge clk);
            if (txb_done) begin
                seen = 1;
                check(exp_q.size() == 0, "R7", "bytes still owed at completion", exp_q.size(), 0);
                check(wb_err == exp_err, exp_err ? ((len == 0) ? "R10" : "R9") : tag,
                      "wb_err", wb_err, exp_err);
                check(wb_ready == (cont && !exp_err), "R8", "wb_ready", wb_ready, cont && !exp_err);
                check(wb_user == user, "R12", "wb_user", wb_user, user);
                check(wb_len == LEN_W'(len), "R12", "wb_len", wb_len, len);
            end
        end
        check(seen, "R7", "completion pulse seen", seen, 1);
        @(negedge clk);
        check(!txb_done, "R7", "completion lasts one cycle", txb_done, 0);
        @(posedge clk);
        #3;
        src_q.delete();
        exp_q.delete();
        err_at = 0;
    endtask

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        repeat (150000) @(posedge clk);
        n_fails++;
        $display("FAIL watchdog: actual timeout expected finish");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end

    initial begin
        repeat (4) @(posedge clk);
        #3;
        rst_n = 1;
        @(negedge clk);
        check(!busy && !fifo_wr && !txb_done && !in_ready, "R1", "reset state idle",
              {busy, fifo_wr, txb_done, in_ready}, 0);

        // R1: start with ready clear is ignored.
        @(posedge clk); #3;
        cur_tag = "R1";
        src_q.push_back(8'h55);
        bd_ready = 0; bd_len = 4; bd_last = 1; bd_start = 1;
        @(posedge clk); #3;
        bd_start = 0;
        begin
            bit any_done = 0, any_busy = 0;
            for (int i = 0; i < 10; i++) begin
                @(negedge clk);
                any_done |= txb_done;
                any_busy |= busy;
            end
            check(!any_busy, "R1", "busy after not-ready start", any_busy, 0);
            check(!any_done, "R1", "completion after not-ready start", any_done, 0);
        end
        @(posedge clk); #3;
        src_q.delete();

        // R4/R5/R2: frames with and without the check sequence.
        run_bd("R4", 5, 1, 1, 0, 0, 0, 0, 0, 0);
        run_bd("R4", 9, 1, 1, 0, 1, 0, 0, 0, 1);
        run_bd("R3", 3, 0, 1, 1, 1, 0, 4, 0, 0);
        cfg_idle_ones = 1;
        run_bd("R5", 4, 1, 0, 0, 0, 0, 3, 0, 0);
        cfg_idle_ones = 0;
        run_bd("R6", 2, 1, 0, 1, 0, 0, 15, 0, 0);

        // R2: stalls from the FIFO and gaps from the source.
        stall_en = 1; gap_en = 1;
        cfg_idle_ones = 1;
        run_bd("R2", 20, 1, 1, 0, 1, 0, 2, 0, 0);
        run_bd("R6", 1, 1, 1, 1, 0, 0, 5, 0, 0);
        stall_en = 0; gap_en = 0;
        cfg_idle_ones = 0;

        // R9: error in the middle of the data phase with continuous mode set.
        run_bd("R9", 10, 1, 1, 1, 0, 0, 2, 4, 0);
        // R10: zero length.
        run_bd("R10", 0, 1, 1, 1, 1, 0, 0, 0, 0);

        // R11: signal-unit delay of 3 ticks.
        tick_en = 1; cfg_sud_en = 1; cfg_sud_delay = 3;
        run_bd("R11", 4, 1, 1, 0, 0, 1, 1, 0, 0);
        check(ticks_before == 3, "R11", "ticks before first byte", ticks_before, 3);
        // R11: feature disabled, no ticks at all, buffer still completes.
        tick_en = 0; cfg_sud_en = 0;
        run_bd("R11", 3, 1, 0, 0, 0, 1, 0, 0, 0);
        check(first_wr, "R11", "bytes sent without delay", first_wr, 1);

        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end
endmodule